// File: doc/BRIEF.md
# Small Content-Addressable Match Table

This block is an eight-entry content-addressable memory for 8-bit keys. A search key is compared against all stored entries at once, and the block returns a hit flag and the index of the matching entry. When more than one entry holds the key, the lowest-numbered matching entry is reported. Search results are registered, so each result appears one clock after its key was applied.

Each entry keeps its key as a set of 16-deep, one-bit match columns, one column per 4-bit nibble of the key. A search reads every column at the nibble value of the search key. An entry hits only when all of its columns return 1. Writing an entry loads its columns serially. A down-counter runs from 15 to 0, and at each step a 1 is shifted into a column when the counter equals that column's nibble of the new key, and a 0 otherwise. A write therefore occupies 16 cycles, and busy is high for that whole time. Searches made while busy is high return an invalid result, and write requests made while busy is high are dropped.

Top module: `cam_match_table`

## Requirements
- R1: After reset, busy is low, no search can hit (srch_hit = 0, srch_idx = 0), and every entry's columns are cleared.
- R2: With busy low, a key applied on srch_key before a rising edge produces srch_valid = 1 after that edge, with srch_hit = 1 exactly when some written entry holds that key.
- R3: On a hit, srch_idx gives the number (0 to 7) of the matching entry. On a miss, or on an invalid result, srch_hit = 0 and srch_idx = 0.
- R4: When several entries hold the searched key, srch_idx reports the lowest-numbered one.
- R5: If wr_start is high at a rising edge while busy is low, the block captures wr_idx and wr_key. Busy is high after that edge and stays high for exactly 16 cycles.
- R6: Once busy falls, the written entry matches its new key on the next search, and any key previously held by that entry no longer matches it.
- R7: If wr_start is high while busy is high, the request is ignored: the ongoing write finishes unchanged and the ignored key is never stored.
- R8: A search sampled while busy is high gives srch_valid = 0, srch_hit = 0 and srch_idx = 0.
- R9: A write changes only the entry selected by wr_idx. All other entries keep their keys.
- R10: A match needs both nibbles to agree. A key that differs from the stored key in only the upper nibble, or only the lower nibble, does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| srch_key | input | 8 | Key to look up |
| srch_valid | output | 1 | Result was taken while idle (not busy) |
| srch_hit | output | 1 | Some entry holds the key |
| srch_idx | output | 3 | Lowest matching entry number, 0 on a miss |
| wr_start | input | 1 | Write request strobe, honoured only while idle |
| wr_idx | input | 3 | Entry to write |
| wr_key | input | 8 | Key to store |
| busy | output | 1 | Write in progress |

## Verification
Each search result is due one rising edge after its key is applied. The bench drives srch_key at a falling edge and samples the three result outputs 1 ns after the next rising edge. A write request driven at a falling edge raises busy at the next rising edge. The bench then counts busy-high falling edges and expects exactly 16, and it issues the next search only after busy has dropped. Invalid results are checked by sampling a search during a write, and the ignored write by searching for its key once the write in progress has finished.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic {WS_IDLE = 1'b0, WS_LOAD = 1'b1} wr_state_t;
endpackage

// File: rtl/cam_column.sv
module cam_column #(
   parameter int NIB_W = 4,
   localparam int DEPTH = 1 << NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             shift_bit,
   input  logic [NIB_W-1:0] rd_addr,
   output logic             rd_bit
);
   logic [DEPTH-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr <= '0;
      else if (shift_en) sr <= {sr[DEPTH-2:0], shift_bit};
   end

   assign rd_bit = sr[rd_addr];

   AST_COLUMN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sr)); // R9
endmodule

// File: rtl/cam_entry.sv
module cam_entry #(
   parameter int KEY_W = 8,
   parameter int NIB_W = 4,
   localparam int NIBS = KEY_W / NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic [NIB_W-1:0] step,
   input  logic [KEY_W-1:0] new_key,
   input  logic [KEY_W-1:0] srch_key,
   output logic             match
);
   logic [NIBS-1:0] col_hit;

   for (genvar n = 0; n < NIBS; n++) begin : g_col
      logic bit_in;
      assign bit_in = (step == new_key[n*NIB_W +: NIB_W]);
      cam_column #(.NIB_W(NIB_W)) u_col (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (shift_en),
         .shift_bit(bit_in),
         .rd_addr  (srch_key[n*NIB_W +: NIB_W]),
         .rd_bit   (col_hit[n])
      );
   end

   assign match = &col_hit;
endmodule

// File: rtl/cam_write_seq.sv
module cam_write_seq
   import cam_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int KEY_W   = 8,
   parameter int NIB_W   = 4,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam logic [NIB_W-1:0] LAST = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_start,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [KEY_W-1:0]   wr_key,
   output logic               busy,
   output logic [NIB_W-1:0]   step,
   output logic [KEY_W-1:0]   cur_key,
   output logic [ENTRIES-1:0] shift_en
);
   wr_state_t      state;
   logic [IDX_W-1:0] cur_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= WS_IDLE;
         step    <= '0;
         cur_idx <= '0;
         cur_key <= '0;
      end else begin
         case (state)
            WS_IDLE: if (wr_start) begin
               state   <= WS_LOAD;
               step    <= LAST;
               cur_idx <= wr_idx;
               cur_key <= wr_key;
            end
            WS_LOAD: begin
               if (step == '0) state <= WS_IDLE;
               else            step  <= step - 1'b1;
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

   assign busy = (state == WS_LOAD);

   always_comb begin
      shift_en = '0;
      if (busy) shift_en[cur_idx] = 1'b1;
   end

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (step != '0) |=> busy); // R5
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_start |=> $stable(cur_idx) && $stable(cur_key)); // R7
   AST_ONE_ENTRY_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(shift_en)); // R9
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
   parameter int ENTRIES = 8,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (req[i]) idx = IDX_W'(i);
   end
   assign any = |req;
endmodule

// File: rtl/cam_match_table.sv
module cam_match_table #(
   parameter int ENTRIES = 8,
   parameter int KEY_W   = 8,
   parameter int NIB_W   = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] srch_key,
   output logic             srch_valid,
   output logic             srch_hit,
   output logic [IDX_W-1:0] srch_idx,
   input  logic             wr_start,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [KEY_W-1:0] wr_key,
   output logic             busy
);
   if (KEY_W % NIB_W != 0) begin : g_bad_split
      $error("KEY_W must be a multiple of NIB_W");
   end
   if (ENTRIES < 2 || NIB_W < 1) begin : g_bad_size
      $error("need at least two entries and a nibble of one bit");
   end

   logic [NIB_W-1:0]   step;
   logic [KEY_W-1:0]   cur_key;
   logic [ENTRIES-1:0] shift_en;
   logic [ENTRIES-1:0] match;
   logic               any;
   logic [IDX_W-1:0]   enc_idx;

   cam_write_seq #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .NIB_W(NIB_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_start(wr_start),
      .wr_idx  (wr_idx),
      .wr_key  (wr_key),
      .busy    (busy),
      .step    (step),
      .cur_key (cur_key),
      .shift_en(shift_en)
   );

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      cam_entry #(.KEY_W(KEY_W), .NIB_W(NIB_W)) u_entry (
         .clk     (clk),
         .rst_n   (rst_n),
         .shift_en(shift_en[e]),
         .step    (step),
         .new_key (cur_key),
         .srch_key(srch_key),
         .match   (match[e])
      );
   end

   cam_prio_enc #(.ENTRIES(ENTRIES)) u_enc (
      .req(match),
      .any(any),
      .idx(enc_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srch_valid <= 1'b0;
         srch_hit   <= 1'b0;
         srch_idx   <= '0;
      end else if (busy) begin
         srch_valid <= 1'b0;
         srch_hit   <= 1'b0;
         srch_idx   <= '0;
      end else begin
         srch_valid <= 1'b1;
         srch_hit   <= any;
         srch_idx   <= any ? enc_idx : '0;
      end
   end

   AST_INVALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !srch_valid && !srch_hit); // R8
   AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_hit |-> srch_idx == '0); // R3
   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      srch_hit |-> srch_valid); // R2
endmodule

// File: tb/cam_match_table_test.sv
module cam_match_table_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] srch_key = '0;
   logic       srch_valid, srch_hit, busy;
   logic [2:0] srch_idx;
   logic       wr_start = 1'b0;
   logic [2:0] wr_idx = '0;
   logic [7:0] wr_key = '0;

   int total = 0;
   int bad   = 0;
   bit       m_used [8];
   logic [7:0] m_key [8];

   always #10 clk = ~clk;

   cam_match_table uut (
      .clk(clk), .rst_n(rst_n), .srch_key(srch_key), .srch_valid(srch_valid),
      .srch_hit(srch_hit), .srch_idx(srch_idx), .wr_start(wr_start),
      .wr_idx(wr_idx), .wr_key(wr_key), .busy(busy)
   );

   task automatic chk(string tag, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   function automatic int exp_idx(logic [7:0] k);
      for (int i = 0; i < 8; i++) if (m_used[i] && m_key[i] == k) return i;
      return -1;
   endfunction

   task automatic do_write(logic [2:0] idx, logic [7:0] key);
      int n = 0;
      @(negedge clk);
      wr_start = 1'b1; wr_idx = idx; wr_key = key;
      @(negedge clk);
      wr_start = 1'b0;
      chk("R5 busy rises", int'(busy), 1);
      while (busy && n < 40) begin n++; @(negedge clk); end
      chk("R5 busy length", n, 16);
      m_used[idx] = 1'b1; m_key[idx] = key;
   endtask

   task automatic do_search(string tag, logic [7:0] key);
      int e = exp_idx(key);
      @(negedge clk);
      srch_key = key;
      @(posedge clk); #1;
      chk({tag, " valid"}, int'(srch_valid), 1);
      chk({tag, " hit"}, int'(srch_hit), (e >= 0) ? 1 : 0);
      chk({tag, " idx"}, int'(srch_idx), (e >= 0) ? e : 0);
   endtask

   initial begin
      #3_000_000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 8; i++) begin m_used[i] = 1'b0; m_key[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 no hit after reset", int'(srch_hit), 0);
      do_search("R1 cleared key 00", 8'h00);
      do_search("R1 cleared key FF", 8'hFF);

      do_write(3'd0, 8'h3C);
      do_search("R2 stored 3C", 8'h3C);
      do_search("R10 upper nibble differs", 8'h4C);
      do_search("R10 lower nibble differs", 8'h3D);

      do_write(3'd6, 8'h77);
      do_write(3'd3, 8'h77);
      do_search("R4 lowest of 3 and 6", 8'h77);
      do_write(3'd3, 8'h11);
      do_search("R6 old key leaves entry 3", 8'h77);
      do_search("R6 new key in entry 3", 8'h11);
      do_search("R9 entry 0 kept", 8'h3C);

      // R7 and R8: request during a write, search during a write
      @(negedge clk);
      wr_start = 1'b1; wr_idx = 3'd2; wr_key = 8'hA5;
      @(negedge clk);
      wr_start = 1'b0;
      repeat (3) @(negedge clk);
      wr_start = 1'b1; wr_idx = 3'd5; wr_key = 8'hEE;
      srch_key = 8'h3C;
      @(posedge clk); #1;
      chk("R8 valid while busy", int'(srch_valid), 0);
      chk("R8 hit while busy", int'(srch_hit), 0);
      chk("R8 idx while busy", int'(srch_idx), 0);
      @(negedge clk);
      wr_start = 1'b0;
      while (busy) @(negedge clk);
      m_used[2] = 1'b1; m_key[2] = 8'hA5;
      do_search("R7 ignored key absent", 8'hEE);
      do_search("R7 running write completed", 8'hA5);

      for (int it = 0; it < 60; it++) begin
         logic [7:0] k = 8'($urandom);
         if (k == 8'hEE) k = 8'hEF;
         if ($urandom % 3 == 0) begin
            do_write(3'($urandom), k);
         end else begin
            if ($urandom % 2 == 0) begin
               int j = int'($urandom % 8);
               if (m_used[j]) k = m_key[j];
            end
            do_search("R2 random search", k);
         end
      end
      do_search("R9 random final EE", 8'hEE);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule